// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Write Sequencer

This block runs a single write transaction against a three-wire serial EEPROM from the host side. A one-cycle start pulse latches an address, a data word and an organisation select. The block then drives chip select, a divided serial clock and the serial data line. It sends a start marker, the write opcode, the address and either 8 or 16 data bits, with a program-enable line held high across the data phase.

Once the last bit has gone out, the device's self-timed programming cycle begins. Build-time parameters select how. In one variant the block deselects the device and waits out a minimum low time before selecting it again to read status. In the other variant the last rising clock edge already starts the cycle, so chip select stays high and polling begins at once. During polling, the device's status line is resynchronised to the system clock and watched for the ready level.

When ready is seen, one more start marker is clocked in and the device is deselected, which clears the status indication. A one-cycle done pulse ends the transaction. If ready is not seen in time, the block deselects the device and pulses an error instead.

Top module: `mw_prog_writer`

## Requirements
- R1: After reset and whenever no transaction is running, chip select, serial clock, program enable, busy, done and error are all low.
- R2: Serial data changes only while the serial clock is low, and the serial clock is high only while chip select is high. The bits seen at the rising clock edges are 1, 0, 1, then the address most significant bit first, then the data most significant bit first.
- R3: With the organisation select at 1 the data field is all 16 bits of the data input; with it at 0 the data field is data bits 7 down to 0 (8 bits).
- R4: Program enable is high at the rising serial clock edge that carries the last data bit, and falls only while the serial clock is low.
- R5: With the deselect trigger variant, chip select goes low after the last data bit and stays low for at least 250 ns worth of system clocks (32 clocks at 125 MHz) before it rises again for polling.
- R6: With the clock-edge trigger variant, chip select stays high from the first bit through polling and the clear step, and falls exactly once per transaction.
- R7: A done pulse follows only after the device has driven its status line high while selected.
- R8: After ready, exactly one further serial clock rising edge with serial data at 1 occurs, then chip select falls; chip select is low when done pulses.
- R9: If ready is not seen, chip select falls and error pulses exactly POLL_MAX+2 system clocks after polling began; done does not pulse for that transaction.
- R10: Busy rises on the clock after an accepted start and falls in the same cycle that done or error pulses; done and error last one clock each and never coincide.
- R11: A start pulse while busy is ignored: the transaction in progress sends its original address and data and ends with a single done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a write |
| addr_i | input | ADDR_W | Target address, latched at start |
| data_i | input | 16 | Write data, latched at start |
| word_i | input | 1 | 1 selects 16-bit organisation, 0 selects 8-bit |
| do_i | input | 1 | Device status/data-out line |
| cs_o | output | 1 | Device chip select, active high |
| sk_o | output | 1 | Serial clock to the device |
| di_o | output | 1 | Serial data to the device |
| pe_o | output | 1 | Program enable to the device |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse on poll timeout |

## Verification
The bench builds two copies side by side, one with the deselect trigger and one with the clock-edge trigger. This lets the different chip-select behaviour of the two variants be checked on the same stimulus. Both use a 6-bit address, a serial-clock half-period of two system clocks and a 125 MHz system clock frequency parameter, which yields a 32-clock minimum gap. The poll limit is cut to 300 clocks, so a device that never finishes programming reaches the timeout within a short run and the exact cycle of the error pulse can be checked.

// File: rtl/mw_prog_writer.sv
module mw_prog_writer #(
  parameter int ADDR_W     = 7,
  parameter int CLK_HZ     = 125_000_000,
  parameter int DIV        = 4,
  parameter bit TRIG_ON_CS = 1'b1,
  parameter int POLL_MAX   = 50_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              word_i,
  input  logic              do_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              pe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int NB    = 3 + ADDR_W + 16;
  localparam int GAP_R = ((CLK_HZ / 1000) * 250 + 999_999) / 1_000_000;
  localparam int GAP   = (GAP_R < 1) ? 1 : GAP_R;
  localparam int TW    = $clog2(POLL_MAX + GAP + 4);
  localparam int HW    = $clog2(DIV + 1);
  localparam int BW    = $clog2(NB + 1);

  typedef enum logic [2:0] {IDLE, SHIFT, GAPW, POLL, FIN} st_t;

  st_t           st;
  logic [NB-1:0] sh;
  logic [HW-1:0] hc;
  logic [BW-1:0] left;
  logic [TW-1:0] tmr;
  logic [1:0]    dsy;
  logic          clr, fail;

  wire tick = (hc == HW'(DIV - 1));
  wire last = (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;  sh <= '0;  hc <= '0;  left <= '0;  tmr <= '0;  dsy <= '0;
      clr <= 1'b0;  fail <= 1'b0;
      cs_o <= 1'b0;  sk_o <= 1'b0;  di_o <= 1'b0;  pe_o <= 1'b0;
      busy_o <= 1'b0;  done_o <= 1'b0;  err_o <= 1'b0;
    end else begin
      dsy    <= {dsy[0], do_i};
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        IDLE: if (start_i) begin
          st     <= SHIFT;
          busy_o <= 1'b1;
          cs_o   <= 1'b1;
          pe_o   <= 1'b1;
          di_o   <= 1'b1;
          clr    <= 1'b0;
          fail   <= 1'b0;
          hc     <= '0;
          sh     <= word_i ? {3'b101, addr_i, data_i} : {3'b101, addr_i, data_i[7:0], 8'h00};
          left   <= word_i ? BW'(NB - 1) : BW'(NB - 9);
        end
        SHIFT: begin
          hc <= tick ? '0 : hc + 1'b1;
          if (tick) begin
            sk_o <= ~sk_o;
            if (sk_o) begin
              if (last) begin
                pe_o <= 1'b0;
                tmr  <= '0;
                if (clr) begin
                  cs_o <= 1'b0;
                  st   <= FIN;
                end else if (TRIG_ON_CS) begin
                  cs_o <= 1'b0;
                  st   <= GAPW;
                end else begin
                  st   <= POLL;
                end
              end else begin
                sh   <= sh << 1;
                di_o <= sh[NB-2];
                left <= left - 1'b1;
              end
            end
          end
        end
        GAPW: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(GAP - 1)) begin
            cs_o <= 1'b1;
            tmr  <= '0;
            st   <= POLL;
          end
        end
        POLL: begin
          tmr <= tmr + 1'b1;
          if (tmr >= TW'(3) && dsy[1]) begin
            st   <= SHIFT;
            clr  <= 1'b1;
            di_o <= 1'b1;
            left <= '0;
            hc   <= '0;
          end else if (tmr == TW'(POLL_MAX)) begin
            cs_o <= 1'b0;
            fail <= 1'b1;
            st   <= FIN;
          end
        end
        FIN: begin
          busy_o <= 1'b0;
          done_o <= ~fail;
          err_o  <= fail;
          st     <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_prog_writer_chk.sv
module mw_prog_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic cs_o,
  input logic sk_o,
  input logic di_o,
  input logic pe_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  AST_QUIET_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (!cs_o && !sk_o && !pe_o)); // R1
  AST_SK_SELECTED:    assert property (@(posedge clk) disable iff (!rst_n) sk_o |-> cs_o); // R2
  AST_DI_SETTLED:     assert property (@(posedge clk) disable iff (!rst_n) !$stable(di_o) |-> !sk_o); // R2
  AST_PE_DROP_LOW:    assert property (@(posedge clk) disable iff (!rst_n) $fell(pe_o) |-> !sk_o); // R4
  AST_END_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) (done_o || err_o) |-> !cs_o); // R8
  AST_NO_BOTH:        assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o)); // R9
  AST_DONE_ONCE:      assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
  AST_ERR_ONCE:       assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !err_o); // R10
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (done_o || err_o) |-> $past(busy_o)); // R10
  AST_START_IGNORED:  assert property (@(posedge clk) disable iff (!rst_n) (busy_o && start_i) |=> (busy_o || done_o || err_o)); // R11
endmodule

bind mw_prog_writer mw_prog_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o),
  .pe_o(pe_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/mw_prog_writer_test.sv
module mw_dev_model #(parameter bit TRIG_ON_CS = 1'b1) (
  input  logic        clk,
  input  logic        cs,
  input  logic        sk,
  input  logic        di,
  input  logic        pe,
  input  logic        clr,
  input  logic        hang,
  input  int          nbits,
  input  int          prog_len,
  output logic        dout,
  output logic [63:0] rx,
  output int          cnt,
  output int          gap,
  output int          falls,
  output int          ncyc,
  output int          rise_at,
  output logic        pe_last,
  output logic        cleared
);
  logic [63:0] r_rx = '0;
  int   r_cnt = 0, r_gap = 0, r_falls = 0, n = 0, r_rise = 0, left = 0, low = 0;
  logic r_pe = 1'b0, r_clr = 1'b0, pcs = 1'b0, psk = 1'b0, run = 1'b0, show = 1'b0, seen = 1'b0, r_do = 1'b0;

  assign dout = r_do;   assign rx = r_rx;     assign cnt = r_cnt;   assign gap = r_gap;
  assign falls = r_falls; assign ncyc = n;    assign rise_at = r_rise;
  assign pe_last = r_pe; assign cleared = r_clr;

  always @(negedge clk) begin
    n++;
    if (clr) begin
      r_rx = '0; r_cnt = 0; r_falls = 0; r_pe = 1'b0; r_clr = 1'b0;
      run = 1'b0; show = 1'b0; seen = 1'b0;
    end else begin
      if (cs && !pcs) begin
        r_gap = low; r_rise = n;
        if (seen && !r_clr) show = 1'b1;
      end
      if (!cs && pcs) begin
        r_falls++;
        if (TRIG_ON_CS && r_cnt == nbits && !seen) begin run = 1'b1; seen = 1'b1; left = prog_len; end
      end
      if (cs && sk && !psk) begin
        if (show && !run) begin
          if (di) begin r_clr = 1'b1; show = 1'b0; end
        end else if (!seen) begin
          r_rx = {r_rx[62:0], di};
          r_cnt++;
          if (r_cnt == nbits) begin
            r_pe = pe;
            if (!TRIG_ON_CS) begin run = 1'b1; seen = 1'b1; show = 1'b1; left = prog_len; end
          end
        end
      end
      if (run && !hang) begin
        left--;
        if (left <= 0) run = 1'b0;
      end
    end
    low  = cs ? 0 : low + 1;
    pcs  = cs;
    psk  = sk;
    r_do = cs && show && !run;
  end
endmodule

module mw_prog_writer_test;
  localparam int AW   = 6;
  localparam int DIV  = 2;
  localparam int PM   = 300;
  localparam int GAPC = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;

  logic          st[2], wd[2], cl[2], hg[2], sl[2], act[2], pbz[2];
  logic [AW-1:0] ad[2];
  logic [15:0]   dt[2];
  int            nb[2], pl[2];
  logic          dov[2], cs[2], sk[2], di[2], pe[2], bz[2], dn[2], er[2];
  logic [63:0]   rx[2];
  logic          pel[2], clrd[2];
  int            cnt[2], gap[2], falls[2], ncyc[2], rise[2];

  for (genvar g = 0; g < 2; g++) begin : v
    mw_prog_writer #(.ADDR_W(AW), .CLK_HZ(125_000_000), .DIV(DIV), .TRIG_ON_CS(g == 0), .POLL_MAX(PM)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(st[g]), .addr_i(ad[g]), .data_i(dt[g]), .word_i(wd[g]),
      .do_i(dov[g]), .cs_o(cs[g]), .sk_o(sk[g]), .di_o(di[g]), .pe_o(pe[g]),
      .busy_o(bz[g]), .done_o(dn[g]), .err_o(er[g]));
    mw_dev_model #(.TRIG_ON_CS(g == 0)) dev (
      .clk(clk), .cs(cs[g]), .sk(sk[g]), .di(di[g]), .pe(pe[g]), .clr(cl[g]), .hang(hg[g]),
      .nbits(nb[g]), .prog_len(pl[g]), .dout(dov[g]), .rx(rx[g]), .cnt(cnt[g]), .gap(gap[g]),
      .falls(falls[g]), .ncyc(ncyc[g]), .rise_at(rise[g]), .pe_last(pel[g]), .cleared(clrd[g]));
  end

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  always @(posedge clk) for (int i = 0; i < 2; i++) sl[i] <= st[i];

  // R10 reference: busy expected from an accepted start until done/error, compared every clock
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (!act[i] && sl[i] && !pbz[i]) act[i] = 1'b1;
        checks++;
        if (act[i]) begin
          if (bz[i] !== !(dn[i] | er[i])) begin
            errs++;
            $display("FAIL R10: inst %0d busy got %0b expected %0b", i, bz[i], !(dn[i] | er[i]));
          end
          if (dn[i] | er[i]) act[i] = 1'b0;
        end else if (bz[i] | dn[i] | er[i]) begin
          errs++;
          $display("FAIL R10: inst %0d idle outputs got %0b%0b%0b expected 000", i, bz[i], dn[i], er[i]);
        end
        pbz[i] = bz[i];
      end
    end
    if (cyc > 150_000) begin
      errs++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  task automatic txn(input int i, input logic [AW-1:0] a, input logic [15:0] d, input logic w,
                     input int plen, input logic hang, input logic poke);
    logic [63:0] e;
    int          t;
    e = w ? 64'({3'b101, a, d}) : 64'({3'b101, a, d[7:0]});
    @(negedge clk); #1;
    cl[i] = 1'b1; hg[i] = hang; pl[i] = plen; nb[i] = w ? 3 + AW + 16 : 3 + AW + 8;
    ad[i] = a; dt[i] = d; wd[i] = w;
    @(negedge clk); #1;
    cl[i] = 1'b0; st[i] = 1'b1;
    @(negedge clk); #1;
    st[i] = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      #1; st[i] = 1'b1; ad[i] = ~a; dt[i] = ~d; wd[i] = ~w;
      @(negedge clk); #1; st[i] = 1'b0;
    end
    while (!(dn[i] | er[i])) begin @(negedge clk); #1; end
    t = ncyc[i] - rise[i];
    if (hang) begin
      chk(er[i] === 1'b1 && dn[i] === 1'b0, "R9 error not done", {dn[i], er[i]}, 2'b01);
      chk(t == PM + 2, "R9 timeout cycle", t, PM + 2);
      chk(cs[i] === 1'b0, "R9 deselect", cs[i], 0);
      chk(clrd[i] === 1'b0, "R7 no ready seen", clrd[i], 0);
    end else begin
      chk(dn[i] === 1'b1 && er[i] === 1'b0, "R7 done", {dn[i], er[i]}, 2'b10);
      chk(rx[i] == e, poke ? "R11 original frame" : (w ? "R2 word frame" : "R3 byte frame"), rx[i], e);
      chk(cnt[i] == nb[i], "R3 bit count", cnt[i], nb[i]);
      chk(pel[i] === 1'b1, "R4 program enable", pel[i], 1);
      chk(clrd[i] === 1'b1 && cs[i] === 1'b0, "R8 clear step", {clrd[i], cs[i]}, 2'b10);
      if (i == 0) begin
        chk(gap[i] >= GAPC, "R5 gap", gap[i], GAPC);
        chk(falls[i] == 2, "R5 deselects", falls[i], 2);
      end else begin
        chk(falls[i] == 1, "R6 single deselect", falls[i], 1);
      end
    end
    @(negedge clk); #1;
    chk(dn[i] === 1'b0 && er[i] === 1'b0 && bz[i] === 1'b0, "R10 pulse width", {bz[i], dn[i], er[i]}, 0);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      st[i] = 1'b0; wd[i] = 1'b1; cl[i] = 1'b1; hg[i] = 1'b0; ad[i] = '0; dt[i] = '0;
      nb[i] = 0; pl[i] = 10; act[i] = 1'b0; pbz[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk); #1;
    for (int i = 0; i < 2; i++)
      chk({cs[i], sk[i], pe[i], bz[i], dn[i], er[i]} == 6'b0, "R1 reset state",
          {cs[i], sk[i], pe[i], bz[i], dn[i], er[i]}, 0);
    for (int i = 0; i < 2; i++) begin
      txn(i, 6'h2A, 16'hC3A5, 1'b1, 5,   1'b0, 1'b0);
      txn(i, 6'h15, 16'h005A, 1'b0, 120, 1'b0, 1'b0);
      txn(i, 6'h3F, 16'hFFFF, 1'b1, 250, 1'b0, 1'b0);
      txn(i, 6'h00, 16'h1281, 1'b0, 40,  1'b0, 1'b1);
      txn(i, 6'h21, 16'h8001, 1'b1, 60,  1'b0, 1'b0);
    end
    txn(0, 6'h0C, 16'h7E7E, 1'b1, 10, 1'b1, 1'b0);
    txn(0, 6'h33, 16'h4D00, 1'b0, 30, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk({cs[0], sk[0], pe[0], bz[0]} == 4'b0, "R1 idle after run", {cs[0], sk[0], pe[0], bz[0]}, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule